// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses for a single SDRAM read or write burst. A start strobe supplies a start column, a length code and an ordering mode. From the next clock on, the block puts out one column address per cycle, together with a valid flag, until the burst is over.

For fixed lengths of 2, 4 or 8 beats, the addresses stay inside the aligned block that holds the start column. The column bits above the block offset do not change during the burst. The offset either counts up and wraps at the block edge (linear mode) or is the start offset XOR the beat number (interleaved mode).

A full-row burst starts at any column and counts up through the row, wrapping from the top column to column 0. It runs until the stop input is raised. A full-row burst in interleaved mode, or an undefined length code, raises the error flag for one cycle and produces no addresses.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `valid`, `last` and `err` are all low.
- R2: A start accepted at clock edge n makes `valid` high after edge n, and the first address equals `start_col`. A start is accepted when no burst is running, or on the final beat of a running burst.
- R3: Length codes are: `len_code` 1 = 2 beats, 2 = 4 beats, 3 = 8 beats, 7 = full row. With `ilv` = 0 (linear), beat k has low bits equal to (start + k) modulo the length. The bits above the low bits equal those of `start_col`.
- R4: With `ilv` = 1 and a length of 2, 4 or 8, beat k addresses `start_col` XOR k.
- R5: `last` is high on the final beat of a 2, 4 or 8 beat burst. If no new start is accepted, `valid` is low on the next cycle.
- R6: A full-row burst addresses (start + k) modulo 2^COL_W on beat k. `last` is high on the beat during which `stop` is high, and `valid` is low after that beat.
- R7: A start with `ilv` = 1 and `len_code` = 7 raises `err` for the next cycle only, and `valid` stays low.
- R8: A start with `len_code` 0, 4, 5 or 6 raises `err` for the next cycle only, and `valid` stays low.
- R9: A start accepted on the final beat begins the new burst on the next cycle with no idle cycle between the two bursts.
- R10: `stop` has no effect on a 2, 4 or 8 beat burst. The burst keeps its full length and order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst |
| start_col | input | COL_W | Start column |
| len_code | input | 3 | Burst length code |
| ilv | input | 1 | 1 = interleaved, 0 = linear order |
| stop | input | 1 | Ends a full-row burst on this beat |
| col | output | COL_W | Column address of the current beat |
| valid | output | 1 | `col` holds a beat |
| last | output | 1 | Final beat of the burst |
| err | output | 1 | Previous start used an unsupported combination |

## Verification
The bench builds the block with COL_W = 5, so a full row is 32 columns. With that width every start column can be swept for all three fixed lengths in both orderings. A full-row burst can be run past the top column to show the wrap to 0 within a few dozen cycles. Every length code, including the undefined ones, is also issued in both modes.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             ilv,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last,
  output logic             err
);
  localparam logic [COL_W-1:0] ALL1 = '1;

  logic             act, full_r, ilv_r;
  logic [COL_W-1:0] base, cnt, mask_r;
  logic [COL_W-1:0] mask_d;
  logic             full_d, known_d, ok_d, accept;

  always_comb begin
    mask_d  = '0;
    full_d  = 1'b0;
    known_d = 1'b1;
    case (len_code)
      3'd1:    mask_d = COL_W'(1);
      3'd2:    mask_d = COL_W'(3);
      3'd3:    mask_d = COL_W'(7);
      3'd7:    begin mask_d = ALL1; full_d = 1'b1; end
      default: known_d = 1'b0;
    endcase
  end

  assign ok_d   = known_d && !(full_d && ilv);
  assign last   = act && (full_r ? stop : (cnt == mask_r));
  assign accept = start && (!act || last);
  assign valid  = act;
  assign col    = ilv_r ? (base ^ cnt)
                        : ((base & ~mask_r) | ((base + cnt) & mask_r));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act    <= 1'b0;
      err    <= 1'b0;
      full_r <= 1'b0;
      ilv_r  <= 1'b0;
      base   <= '0;
      cnt    <= '0;
      mask_r <= '0;
    end else begin
      err <= accept && !ok_d;
      if (accept && ok_d) begin
        act    <= 1'b1;
        base   <= start_col;
        cnt    <= '0;
        mask_r <= mask_d;
        full_r <= full_d;
        ilv_r  <= ilv;
      end else if (last) begin
        act <= 1'b0;
      end else if (act) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col,
  input logic             valid,
  input logic             last,
  input logic             err,
  input logic             full_r,
  input logic             ilv_r
);
  // R5
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);

  // R7
  err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !valid);

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && start) |=> (!valid || col == $past(start_col)));

  // R5
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !valid);

  // R9
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && start) |=> (valid || err));

  // R6
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !last && full_r && !ilv_r) |=> (col == $past(col) + 1'b1));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
  .col(col), .valid(valid), .last(last), .err(err),
  .full_r(full_r), .ilv_r(ilv_r)
);

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  localparam int CW = 5;
  localparam int TCLK = 10;

  logic          clk = 0, rst_n = 0, start = 0, ilv = 0, stop = 0;
  logic [CW-1:0] start_col = '0;
  logic [2:0]    len_code = '0;
  logic [CW-1:0] col;
  logic          valid, last, err;
  int            checks = 0, fails = 0;
  bit            done = 0;

  burst_col_seq #(.COL_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .ilv(ilv), .stop(stop),
    .col(col), .valid(valid), .last(last), .err(err)
  );

  always #(TCLK/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int exp_col(int lc, int il, int sc, int k);
    int m;
    m = (lc == 7) ? (1 << CW) - 1 : (1 << lc) - 1;
    if (il != 0) return sc ^ k;
    return (sc & ~m) | ((sc + k) & m);
  endfunction

  task automatic issue(int lc, int il, int sc);
    start = 1; len_code = 3'(lc); ilv = il[0]; start_col = CW'(sc);
    step();
    start = 0;
    #1;
  endtask

  task automatic fixed_burst(int lc, int il, int sc, bit stop_pulse);
    int n;
    n = 1 << lc;
    issue(lc, il, sc);
    for (int k = 0; k < n; k++) begin
      if (k > 0) begin step(); #1; end
      stop = stop_pulse;
      #1;
      chk(il != 0 ? "R4" : "R3", int'(col), exp_col(lc, il, sc, k));
      chk("R2 valid", int'(valid), 1);
      chk(stop_pulse ? "R10 last" : "R5 last", int'(last), (k == n - 1) ? 1 : 0);
    end
    stop = 0;
    step(); #1;
    chk("R5 end", int'(valid), 0);
  endtask

  task automatic row_burst(int sc, int beats);
    issue(7, 0, sc);
    for (int k = 0; k < beats; k++) begin
      if (k > 0) begin step(); #1; end
      stop = (k == beats - 1);
      #1;
      chk("R6 col", int'(col), (sc + k) % (1 << CW));
      chk("R6 last", int'(last), (k == beats - 1) ? 1 : 0);
    end
    step(); stop = 0; #1;
    chk("R6 end", int'(valid), 0);
  endtask

  task automatic bad_start(int lc, int il, string req);
    issue(lc, il, 3);
    chk({req, " err"}, int'(err), 1);
    chk({req, " valid"}, int'(valid), 0);
    step(); #1;
    chk({req, " err clear"}, int'(err), 0);
    chk({req, " still idle"}, int'(valid), 0);
  endtask

  initial begin
    #(TCLK * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1;
    #1;
    chk("R1 valid", int'(valid), 0);
    chk("R1 last", int'(last), 0);
    chk("R1 err", int'(err), 0);
    step();

    for (int lc = 1; lc <= 3; lc++)
      for (int il = 0; il < 2; il++)
        for (int sc = 0; sc < (1 << CW); sc++)
          fixed_burst(lc, il, sc, 1'b0);

    fixed_burst(3, 0, 13, 1'b1);
    fixed_burst(2, 1, 6, 1'b1);

    row_burst(0, 5);
    row_burst(27, 12);
    row_burst(9, 40);
    row_burst(31, 1);

    bad_start(7, 1, "R7");
    for (int lc = 0; lc < 7; lc++)
      if (lc == 0 || lc > 3) begin
        bad_start(lc, 0, "R8");
        bad_start(lc, 1, "R8");
      end

    // R9 back to back: 4-beat linear at 2, then 8-beat interleaved at 21
    issue(2, 0, 2);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) begin step(); #1; end
      chk("R9 first", int'(col), exp_col(2, 0, 2, k));
    end
    start = 1; len_code = 3'd3; ilv = 1'b1; start_col = CW'(21);
    step(); start = 0; #1;
    for (int k = 0; k < 8; k++) begin
      if (k > 0) begin step(); #1; end
      chk("R9 valid", int'(valid), 1);
      chk("R9 col", int'(col), exp_col(3, 1, 21, k));
    end
    step(); #1;
    chk("R9 end", int'(valid), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule